// File: doc/BRIEF.md
# Multicast Frame Mapping Decoder

This block sits at the head of the global load bus that fills the frame stores of a square grid of processing elements, 8 by 8 by default. Each bus transfer brings a 144-bit frame, a 10-bit frame index Z, an element position given as X (column) and Y (row), and a pair of 8-bit selection masks. The decoder turns these into one write-enable line per element. It also drives the Z index and the frame data, which are shared by every frame store.

Each transfer picks its own addressing mode. Unicast writes one element. Broadcast writes every element and ignores the position. Mask multicast writes every element whose column bit and row bit are both set. The mode may differ from one transfer to the next with no idle cycle between them. Transfers are taken only while the array is in load mode, and the decoded write appears exactly one cycle after the transfer is accepted.

Top module: `frame_map_decoder`

## Requirements
- R1: `req_ready_o` is high exactly when `load_mode_i` is high and reset is inactive. A transfer is accepted on a rising clock edge where `req_valid_i` and `req_ready_o` are both high. A request made outside load mode produces no write.
- R2: Mode code 2'b00 (unicast). One cycle after acceptance, `wr_en_o` has only bit Y*8+X set.
- R3: Mode code 2'b01 (broadcast). One cycle after acceptance, all 64 bits of `wr_en_o` are set, whatever the values of X and Y.
- R4: Mode code 2'b10 (mask multicast). One cycle after acceptance, bit y*8+x of `wr_en_o` is set if and only if `col_mask_i[x]` and `row_mask_i[y]` are both 1. An all-zero mask sets no bit.
- R5: Mode code 2'b11 is invalid. One cycle after acceptance, `mode_err_o` is high and `wr_en_o` is all zero.
- R6: One cycle after any accepted transfer, `wr_z_o` and `wr_data_o` carry that transfer's Z and data. For valid mode codes, `mode_err_o` is low.
- R7: In a cycle that follows an edge with no accepted transfer, `wr_en_o` is zero and `mode_err_o` is low. `wr_z_o` and `wr_data_o` keep their previous values.
- R8: While `load_mode_i` is low, `wr_en_o` is all zero. This holds even in the cycle right after an accepted transfer.
- R9: Back-to-back transfers with different mode codes are each decoded by their own mode.
- R10: During reset, `wr_en_o`, `wr_z_o`, `wr_data_o` and `mode_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_mode_i | input | 1 | High while the array is in load mode |
| req_valid_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Transfer can be accepted |
| req_mode_i | input | 2 | Addressing mode: 00 unicast, 01 broadcast, 10 mask, 11 invalid |
| req_x_i | input | 3 | Column of the target element |
| req_y_i | input | 3 | Row of the target element |
| req_z_i | input | 10 | Frame index inside each element |
| col_mask_i | input | 8 | Column selection mask, used in mask mode |
| row_mask_i | input | 8 | Row selection mask, used in mask mode |
| req_data_i | input | 144 | Frame data |
| wr_en_o | output | 64 | Per-element write enable, bit y*8+x |
| wr_z_o | output | 10 | Registered frame index |
| wr_data_o | output | 144 | Registered frame data |
| mode_err_o | output | 1 | Invalid mode seen on the last accepted transfer |

## Verification
A corrupted enable register shows up in the one cycle after a transfer. It can appear as a second element written in unicast, a missing element in broadcast, or an enable count that differs from the product of the set bits in the two masks. A register that fails to clear shows up one cycle later, as a write on an idle cycle or as a write enable while the array is outside load mode. A stale Z or data register shows up on the cycle after acceptance, as the previous transfer's index or frame.

// File: rtl/frame_map_pkg.sv
package frame_map_pkg;
  typedef enum logic [1:0] {
    MAP_SEQ  = 2'b00,
    MAP_ALL  = 2'b01,
    MAP_MASK = 2'b10,
    MAP_BAD  = 2'b11
  } map_mode_e;
endpackage

// File: rtl/frame_map_point.sv
module frame_map_point #(
  parameter int SIDE = 8,
  localparam int CW = $clog2(SIDE),
  localparam int N = SIDE * SIDE
) (
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  output logic [N-1:0]  sel_o
);
  for (genvar yy = 0; yy < SIDE; yy++) begin : g_row
    for (genvar xx = 0; xx < SIDE; xx++) begin : g_col
      assign sel_o[yy*SIDE+xx] = (x_i == CW'(xx)) && (y_i == CW'(yy));
    end
  end
endmodule

// File: rtl/frame_map_grid.sv
module frame_map_grid #(
  parameter int SIDE = 8,
  localparam int N = SIDE * SIDE
) (
  input  logic [SIDE-1:0] col_i,
  input  logic [SIDE-1:0] row_i,
  output logic [N-1:0]    grid_o
);
  for (genvar yy = 0; yy < SIDE; yy++) begin : g_row
    for (genvar xx = 0; xx < SIDE; xx++) begin : g_col
      assign grid_o[yy*SIDE+xx] = col_i[xx] & row_i[yy];
    end
  end
endmodule

// File: rtl/frame_map_sel.sv
module frame_map_sel
  import frame_map_pkg::*;
#(
  parameter int SIDE = 8,
  localparam int CW = $clog2(SIDE),
  localparam int N = SIDE * SIDE
) (
  input  logic [1:0]      mode_i,
  input  logic [CW-1:0]   x_i,
  input  logic [CW-1:0]   y_i,
  input  logic [SIDE-1:0] col_i,
  input  logic [SIDE-1:0] row_i,
  output logic [N-1:0]    en_o,
  output logic            err_o
);
  logic [N-1:0] point_sel;
  logic [N-1:0] grid_sel;
  map_mode_e    mode;

  assign mode = map_mode_e'(mode_i);

  frame_map_point #(.SIDE(SIDE)) u_point (
    .x_i  (x_i),
    .y_i  (y_i),
    .sel_o(point_sel)
  );

  frame_map_grid #(.SIDE(SIDE)) u_grid (
    .col_i (col_i),
    .row_i (row_i),
    .grid_o(grid_sel)
  );

  always_comb begin
    en_o  = '0;
    err_o = 1'b0;
    case (mode)
      MAP_SEQ:  en_o = point_sel;
      MAP_ALL:  en_o = '1;
      MAP_MASK: en_o = grid_sel;
      default:  err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/frame_map_decoder.sv
module frame_map_decoder
  import frame_map_pkg::*;
#(
  parameter int SIDE = 8,
  parameter int Z_W = 10,
  parameter int DATA_W = 144,
  localparam int CW = $clog2(SIDE),
  localparam int N = SIDE * SIDE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_mode_i,
  input  logic [CW-1:0]     req_x_i,
  input  logic [CW-1:0]     req_y_i,
  input  logic [Z_W-1:0]    req_z_i,
  input  logic [SIDE-1:0]   col_mask_i,
  input  logic [SIDE-1:0]   row_mask_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic [N-1:0]      wr_en_o,
  output logic [Z_W-1:0]    wr_z_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mode_err_o
);
  logic              accept;
  logic [N-1:0]      en_d, en_q;
  logic              err_d, err_q;
  logic [Z_W-1:0]    z_q;
  logic [DATA_W-1:0] data_q;

  // no backpressure: accepts whenever the array is loading
  assign req_ready_o = load_mode_i & rst_ni;
  assign accept      = req_valid_i & req_ready_o;

  frame_map_sel #(.SIDE(SIDE)) u_sel (
    .mode_i(req_mode_i),
    .x_i   (req_x_i),
    .y_i   (req_y_i),
    .col_i (col_mask_i),
    .row_i (row_mask_i),
    .en_o  (en_d),
    .err_o (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      err_q <= 1'b0;
    end else begin
      en_q  <= accept ? en_d : '0;
      err_q <= accept & err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q    <= '0;
      data_q <= '0;
    end else if (accept) begin
      z_q    <= req_z_i;
      data_q <= req_data_i;
    end
  end

  // late drop of load mode still suppresses an in-flight write
  assign wr_en_o    = en_q & {N{load_mode_i}};
  assign wr_z_o     = z_q;
  assign wr_data_o  = data_q;
  assign mode_err_o = err_q;

  a_r2_unicast_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(accept) && $past(req_mode_i) == MAP_SEQ && load_mode_i) |-> $onehot(wr_en_o));

  a_r3_broadcast_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(accept) && $past(req_mode_i) == MAP_ALL && load_mode_i) |-> (&wr_en_o));

  a_r4_mask_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(accept) && $past(req_mode_i) == MAP_MASK && load_mode_i) |->
      ($countones(wr_en_o) == $countones($past(col_mask_i)) * $countones($past(row_mask_i))));

  a_r5_bad_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> (wr_en_o == '0));

  a_r6_z_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(accept) |-> (wr_z_o == $past(req_z_i)));

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(accept) |-> (wr_en_o == '0 && !mode_err_o && $stable(wr_z_o)));
endmodule

// File: tb/frame_map_decoder_test.sv
`timescale 1ns/1ps
module frame_map_decoder_test;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_mode_i = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_mode_i = '0;
  logic [2:0]    req_x_i = '0;
  logic [2:0]    req_y_i = '0;
  logic [9:0]    req_z_i = '0;
  logic [7:0]    col_mask_i = '0;
  logic [7:0]    row_mask_i = '0;
  logic [143:0]  req_data_i = '0;
  logic [63:0]   wr_en_o;
  logic [9:0]    wr_z_o;
  logic [143:0]  wr_data_o;
  logic          mode_err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0]   last_z = '0;
  logic [143:0] last_d = '0;

  always #2.5 clk_i = ~clk_i;

  frame_map_decoder uut (.*);

  function automatic logic [63:0] exp_en(logic [1:0] m, logic [2:0] x, logic [2:0] y,
                                         logic [7:0] c, logic [7:0] r);
    logic [63:0] e = '0;
    case (m)
      2'b00: e[int'(y)*8 + int'(x)] = 1'b1;
      2'b01: e = '1;
      2'b10: for (int yy = 0; yy < 8; yy++)
               for (int xx = 0; xx < 8; xx++) e[yy*8+xx] = c[xx] & r[yy];
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [143:0] act, input logic [143:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge (one register stage)
  task automatic send(input string tag, input logic [1:0] m, input logic [2:0] x,
                      input logic [2:0] y, input logic [9:0] z, input logic [7:0] c,
                      input logic [7:0] r, input logic [143:0] d);
    req_valid_i = 1'b1; req_mode_i = m; req_x_i = x; req_y_i = y;
    req_z_i = z; col_mask_i = c; row_mask_i = r; req_data_i = d;
    @(negedge clk_i);
    check(tag, 144'(wr_en_o), 144'(exp_en(m, x, y, c, r)));
    check("R6", 144'(wr_z_o), 144'(z));
    check("R6", wr_data_o, d);
    check(m == 2'b11 ? "R5" : "R6", 144'(mode_err_o), 144'(m == 2'b11));
    last_z = z; last_d = d;
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    req_mode_i = 2'($urandom);
    @(negedge clk_i);
    check("R7", 144'(wr_en_o), 144'(0));
    check("R7", 144'(mode_err_o), 144'(0));
    check("R7", 144'(wr_z_o), 144'(last_z));
    check("R7", wr_data_o, last_d);
  endtask

  function automatic logic [143:0] rnd_data();
    return {$urandom, $urandom, $urandom, $urandom, 16'($urandom)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk_i);
    load_mode_i = 1'b1;
    @(negedge clk_i);
    // R10 reset state, R1 no ready in reset
    check("R10", 144'(wr_en_o), 144'(0));
    check("R10", 144'(wr_z_o), 144'(0));
    check("R10", wr_data_o, 144'(0));
    check("R10", 144'(mode_err_o), 144'(0));
    check("R1", 144'(req_ready_o), 144'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 144'(req_ready_o), 144'(1));

    // unicast corners
    send("R2", 2'b00, 3'd0, 3'd0, 10'd0, 8'hff, 8'hff, 144'h1);
    send("R2", 2'b00, 3'd7, 3'd7, 10'h3ff, 8'h00, 8'h00, '1);
    send("R2", 2'b00, 3'd5, 3'd2, 10'd17, 8'h00, 8'h00, 144'hbeef);
    idle();
    // broadcast ignores position
    send("R3", 2'b01, 3'd3, 3'd6, 10'd99, 8'h00, 8'h00, 144'hcafe);
    // mask corners
    send("R4", 2'b10, 3'd0, 3'd0, 10'd5, 8'h00, 8'h00, 144'h5);
    send("R4", 2'b10, 3'd0, 3'd0, 10'd6, 8'hff, 8'h00, 144'h6);
    send("R4", 2'b10, 3'd0, 3'd0, 10'd7, 8'hff, 8'hff, 144'h7);
    send("R4", 2'b10, 3'd0, 3'd0, 10'd8, 8'h81, 8'h42, 144'h8);
    // invalid mode
    send("R5", 2'b11, 3'd1, 3'd1, 10'd9, 8'hff, 8'hff, 144'h9);
    idle();
    // R9 back-to-back mode changes
    send("R9", 2'b00, 3'd2, 3'd4, 10'd1, 8'h0f, 8'hf0, 144'ha);
    send("R9", 2'b10, 3'd2, 3'd4, 10'd2, 8'h0f, 8'hf0, 144'hb);
    send("R9", 2'b01, 3'd2, 3'd4, 10'd3, 8'h0f, 8'hf0, 144'hc);
    send("R9", 2'b11, 3'd2, 3'd4, 10'd4, 8'h0f, 8'hf0, 144'hd);
    send("R9", 2'b00, 3'd6, 3'd1, 10'd5, 8'h0f, 8'hf0, 144'he);
    idle();

    // R8 load mode dropped right after acceptance
    req_valid_i = 1'b1; req_mode_i = 2'b01; req_z_i = 10'd50; req_data_i = 144'h50;
    @(posedge clk_i);
    #1 load_mode_i = 1'b0; req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R8", 144'(wr_en_o), 144'(0));
    check("R1", 144'(req_ready_o), 144'(0));
    last_z = 10'd50; last_d = 144'h50;
    // R1 request outside load mode is not taken
    req_valid_i = 1'b1; req_mode_i = 2'b01; req_z_i = 10'd77; req_data_i = 144'h77;
    @(negedge clk_i);
    check("R1", 144'(wr_en_o), 144'(0));
    req_valid_i = 1'b0;
    load_mode_i = 1'b1;
    @(negedge clk_i);
    check("R1", 144'(wr_en_o), 144'(0));
    check("R1", 144'(wr_z_o), 144'(last_z));

    // random mix, idle gaps
    for (int i = 0; i < 500; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      send(mtag(m), m, 3'($urandom), 3'($urandom), 10'($urandom),
           8'($urandom), 8'($urandom), rnd_data());
      if ($urandom_range(3) == 0) idle();
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule